// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns serial audio from up to four data lines into parallel 24-bit channel samples. Every line shares one bit clock and one frame clock. A 2-bit format code picks either two-channel stereo framing on each line, or time-division framing with 32-bit slots on one line or on two lines. The delay from the frame edge to the MSB can be set, which covers the usual I2S, left-justified and right-justified placements. The word width, the frame length and the polarity of both clocks can also be set. A pipeline option moves the sampling point to the end of the bit period.

All inputs are sampled by the system clock, so the serial clocks are treated as slow data. When the frame clock enters its left level, a new frame starts. At that point the samples gathered during the frame just finished are presented on a flat output bus, together with a one-cycle valid strobe. In master mode the block drives the bit clock and the frame clock from counters on the system clock, and it receives on those same clocks.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is held, and after it until the first publish, `smp_o` is all zeros and `frame_vld_o` is low. `clk_oe` is low when `cfg_master` is 0.
- R2: A frame starts on the first capture edge at which the logical frame clock is 0 (left) after having been 1. At every frame start except the first after reset, the samples of the finished frame appear on `smp_o` and `frame_vld_o` is high for exactly one cycle. At all other times `smp_o` holds its value.
- R3: Format 00 (stereo): line k carries channel 2k in the left half and channel 2k+1 in the right half. Each half is frame_length/2 bit clocks long. The right half begins at the capture edge where the frame clock enters its right level.
- R4: Formats 01 and 10 (TDM): line 0 carries 32-bit slots from the frame start, and slot s goes to channel s. Slots at or above 8 are ignored. Format 11 (dual-line TDM): slots 0..3 of line 0 go to channels 0..3, and slots 0..3 of line 1 go to channels 4..7.
- R5: The delay code sets how many bit clocks come between the start of a half or slot and the MSB: 000→1, 001→0, 010→8, 011→12, 100→16. Every other code behaves as 1.
- R6: The width code gives 24 bits (00), 20 bits (01), 16 bits (11), or 24 bits (10). Data arrives MSB first. Each sample is left-aligned in its 24-bit field, with zeros below it. Channel c occupies `smp_o[24c+23:24c]`.
- R7: The frame-length code gives 64 (00), 128 (01), 256 (10) or 512 (11) bit clocks. A channel that the format and length do not carry reads as zero.
- R8: `cfg_lr_pol`=0 marks left with a low frame clock pin, and 1 marks left with a high one.
- R9: Data is captured on the rising edge of `bclk_i` XOR `cfg_bclk_inv`. With `cfg_pipe`=1 it is captured on the falling edge of that signal instead.
- R10: With `cfg_master`=1, `clk_oe` is high and `bclk_o` toggles every BCLK_HALF system cycles. `lrclk_o` changes only at a falling edge of the effective bit clock, and shows left for the first half of each frame. The receiver uses these clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 2 | Format code (R3, R4) |
| cfg_len | input | 2 | Frame-length code |
| cfg_delay | input | 3 | Data-delay code |
| cfg_width | input | 2 | Word-width code |
| cfg_lr_pol | input | 1 | Frame clock polarity |
| cfg_bclk_inv | input | 1 | Bit clock inversion |
| cfg_pipe | input | 1 | Capture on the falling effective edge |
| cfg_master | input | 1 | Generate clocks internally |
| bclk_i | input | 1 | Bit clock pin in slave mode |
| lrclk_i | input | 1 | Frame clock pin in slave mode |
| sdata_i | input | LINES | Serial data lines |
| bclk_o | output | 1 | Generated bit clock |
| lrclk_o | output | 1 | Generated frame clock |
| clk_oe | output | 1 | Drive enable for the generated clocks |
| smp_o | output | CHANS*24 | Channel samples, channel 0 in the low bits |
| frame_vld_o | output | 1 | One-cycle strobe when new samples are presented |

## Verification
The assertions assume three things about the inputs. The configuration changes only while reset is held. Each bit-clock half period lasts at least three system cycles, so the synchronizers see every edge. Data and frame clock change only at the launch edge, which is the edge opposite the capture edge. The bench changes configuration only inside reset and drives bit-clock halves of three cycles. It changes data and frame clock only at launch edges, also in pipeline mode and with an inverted clock. In master mode it drives data on the falling edges it observes on the generated clock.

// File: rtl/audio_rx_pkg.sv
// Shared constants and code decoders for the serial audio receiver.
// Assumes codes are sampled as static configuration.
package audio_rx_pkg;

    localparam int SAMPLE_W  = 24;
    localparam int SLOT_BITS = 32;

    typedef enum logic [1:0] {
        FMT_STEREO    = 2'b00,
        FMT_TDM_CHAIN = 2'b01,
        FMT_TDM_AUX   = 2'b10,
        FMT_TDM_DUAL  = 2'b11
    } rx_fmt_e;

    // Bit clocks between a half or slot start and the MSB
    function automatic logic [4:0] delay_bits(input logic [2:0] code);
        case (code)
            3'b000:  return 5'd1;
            3'b001:  return 5'd0;
            3'b010:  return 5'd8;
            3'b011:  return 5'd12;
            3'b100:  return 5'd16;
            default: return 5'd1;
        endcase
    endfunction

    // Number of data bits per sample
    function automatic logic [4:0] word_bits(input logic [1:0] code);
        case (code)
            2'b01:   return 5'd20;
            2'b11:   return 5'd16;
            default: return 5'd24;
        endcase
    endfunction

    // Bit clocks per frame
    function automatic logic [9:0] frame_bits(input logic [1:0] code);
        return 10'd64 << code;
    endfunction

endpackage

// File: rtl/aud_rx_clkgen.sv
// Master-mode clock generator. Divides the system clock into a bit clock
// (BCLK_HALF cycles per half period) and derives a frame clock that is
// left (0) for the first half of the frame and changes on falling edges.
// Assumes frame length is held static while enabled.
module aud_rx_clkgen #(
    parameter int BCLK_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [9:0] len_bits,
    output logic       bclk_q,
    output logic       lr_q
);
    localparam int CW = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;

    logic [CW-1:0] div_q;
    logic [9:0]    bit_q;
    logic [9:0]    bit_nxt;
    logic [9:0]    half_bits;

    // Next bit index at a falling edge, wrapping at frame end
    always_comb begin
        half_bits = len_bits >> 1;
        bit_nxt   = (bit_q == len_bits - 10'd1) ? 10'd0 : bit_q + 10'd1;
    end

    // Divider, bit counter and frame clock registers
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_q  <= '0;
            bclk_q <= 1'b0;
            bit_q  <= '0;
            lr_q   <= 1'b0;
        end else if (div_q == CW'(BCLK_HALF - 1)) begin
            div_q  <= '0;
            bclk_q <= ~bclk_q;
            if (bclk_q) begin
                bit_q <= bit_nxt;
                lr_q  <= (bit_nxt >= half_bits);
            end
        end else begin
            div_q <= div_q + CW'(1);
        end
    end

endmodule

// File: rtl/aud_rx_sampler.sv
// Front end: synchronizes bit clock, frame clock and data lines to the
// system clock and emits one capture strobe per selected bit-clock edge,
// with the frame level (0 = left) and data bits seen at that edge.
// Assumes each bit-clock half period spans at least three system cycles.
module aud_rx_sampler #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_src,
    input  logic             lr_src,
    input  logic [LINES-1:0] dat_src,
    input  logic             bclk_inv,
    input  logic             lr_pol,
    input  logic             pipe,
    output logic             cap_stb,
    output logic             cap_lr,
    output logic [LINES-1:0] cap_dat
);
    logic             b1_q, b2_q, b3_q;
    logic             l1_q, l2_q;
    logic [LINES-1:0] d1_q, d2_q;
    logic             b_now, b_prev, edge_hit;

    // Two-stage synchronizers plus one history stage for the bit clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {b1_q, b2_q, b3_q} <= '0;
            {l1_q, l2_q}       <= '0;
            d1_q               <= '0;
            d2_q               <= '0;
        end else begin
            b1_q <= bclk_src;
            b2_q <= b1_q;
            b3_q <= b2_q;
            l1_q <= lr_src;
            l2_q <= l1_q;
            d1_q <= dat_src;
            d2_q <= d1_q;
        end
    end

    // Capture edge selection from polarity and pipeline option
    always_comb begin
        b_now    = b2_q ^ bclk_inv;
        b_prev   = b3_q ^ bclk_inv;
        edge_hit = pipe ? (b_prev & ~b_now) : (~b_prev & b_now);
    end

    // Registered strobe with aligned frame level and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_stb <= 1'b0;
            cap_lr  <= 1'b0;
            cap_dat <= '0;
        end else begin
            cap_stb <= edge_hit;
            cap_lr  <= l2_q ^ lr_pol;
            cap_dat <= d2_q;
        end
    end

endmodule

// File: rtl/aud_rx_deser.sv
// Deserializer: tracks the bit index inside the frame, routes each
// captured bit to the channel whose window covers it, left-aligns it into
// a 24-bit assembly register and publishes all channels at frame start.
// Assumes configuration is static between resets.
module aud_rx_deser
    import audio_rx_pkg::*;
#(
    parameter int LINES = 4,
    parameter int CHANS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cap_stb,
    input  logic                      cap_lr,
    input  logic [LINES-1:0]          cap_dat,
    input  logic [1:0]                fmt,
    input  logic [9:0]                len_bits,
    input  logic [4:0]                dly,
    input  logic [4:0]                wid,
    output logic [CHANS*SAMPLE_W-1:0] smp_o,
    output logic                      vld_o
);
    logic [9:0]                idx_q, idx_n, half_bits;
    logic                      lr_prev_q, armed_q;
    logic                      start, rstart, stereo;
    logic [CHANS*SAMPLE_W-1:0] asm_flat;

    // Frame and half boundary detection, next bit index
    always_comb begin
        stereo    = (fmt == FMT_STEREO);
        half_bits = len_bits >> 1;
        start     = cap_stb & lr_prev_q & ~cap_lr;
        rstart    = cap_stb & stereo & ~lr_prev_q & cap_lr;
        idx_n     = idx_q;
        if (start)
            idx_n = 10'd0;
        else if (rstart)
            idx_n = half_bits;
        else if (cap_stb && idx_q != 10'h3FF)
            idx_n = idx_q + 10'd1;
    end

    // Bit index and previous frame level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            lr_prev_q <= 1'b0;
        end else if (cap_stb) begin
            idx_q     <= idx_n;
            lr_prev_q <= cap_lr;
        end
    end

    for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
        localparam bit         ST_OK  = (ch / 2) < LINES;
        localparam int         ST_LN  = ST_OK ? ch / 2 : 0;
        localparam bit         DU_OK  = (ch < 8) && ((ch / 4) < LINES);
        localparam int         DU_LN  = DU_OK ? ch / 4 : 0;
        localparam logic [10:0] TDM_OFF = 11'(ch * SLOT_BITS);
        localparam logic [10:0] DU_OFF  = 11'((ch % 4) * SLOT_BITS);
        localparam bit         ODD    = (ch % 2) == 1;

        logic                ok, bitv, hit;
        logic [10:0]         base0, base, off;
        logic [4:0]          bpos;
        logic [SAMPLE_W-1:0] asm_q, asm_nxt;

        // Window of this channel under the current format
        always_comb begin
            case (fmt)
                FMT_STEREO: begin
                    ok    = ST_OK;
                    bitv  = cap_dat[ST_LN];
                    base0 = ODD ? {1'b0, half_bits} : 11'd0;
                end
                FMT_TDM_DUAL: begin
                    ok    = DU_OK && (DU_OFF < {1'b0, len_bits});
                    bitv  = cap_dat[DU_LN];
                    base0 = DU_OFF;
                end
                default: begin
                    ok    = (ch < 8) && (TDM_OFF < {1'b0, len_bits});
                    bitv  = cap_dat[0];
                    base0 = TDM_OFF;
                end
            endcase
            base    = base0 + {6'd0, dly};
            off     = {1'b0, idx_n} - base;
            hit     = cap_stb && ok && ({1'b0, idx_n} >= base)
                      && (off < {6'd0, wid});
            bpos    = 5'(SAMPLE_W - 1) - off[4:0];
            asm_nxt = start ? '0 : asm_q;
            if (hit)
                asm_nxt[bpos] = bitv;
        end

        // Assembly register for this channel
        always_ff @(posedge clk) begin
            if (!rst_n)
                asm_q <= '0;
            else if (cap_stb)
                asm_q <= asm_nxt;
        end

        assign asm_flat[ch*SAMPLE_W +: SAMPLE_W] = asm_q;
    end

    // Publish finished frame at each frame start after the first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_o   <= '0;
            vld_o   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (start) begin
                armed_q <= 1'b1;
                if (armed_q) begin
                    smp_o <= asm_flat;
                    vld_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/audio_serial_rx.sv
// Top of the multi-format serial audio receiver. Decodes configuration,
// selects pin or generated clocks, and connects the front end, the
// deserializer and the master clock generator.
// Assumes configuration changes only while reset is held.
module audio_serial_rx
    import audio_rx_pkg::*;
#(
    parameter int LINES     = 4,
    parameter int CHANS     = 8,
    parameter int BCLK_HALF = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                cfg_fmt,
    input  logic [1:0]                cfg_len,
    input  logic [2:0]                cfg_delay,
    input  logic [1:0]                cfg_width,
    input  logic                      cfg_lr_pol,
    input  logic                      cfg_bclk_inv,
    input  logic                      cfg_pipe,
    input  logic                      cfg_master,
    input  logic                      bclk_i,
    input  logic                      lrclk_i,
    input  logic [LINES-1:0]          sdata_i,
    output logic                      bclk_o,
    output logic                      lrclk_o,
    output logic                      clk_oe,
    output logic [CHANS*SAMPLE_W-1:0] smp_o,
    output logic                      frame_vld_o
);
    logic [9:0]       len_bits;
    logic [4:0]       dly_bits, wid_bits;
    logic             gen_bclk, gen_lr;
    logic             bclk_src, lr_src;
    logic             cap_stb, cap_lr;
    logic [LINES-1:0] cap_dat;

    // Configuration decode and clock source selection
    always_comb begin
        len_bits = frame_bits(cfg_len);
        dly_bits = delay_bits(cfg_delay);
        wid_bits = word_bits(cfg_width);
        bclk_o   = gen_bclk ^ cfg_bclk_inv;
        lrclk_o  = gen_lr ^ cfg_lr_pol;
        clk_oe   = cfg_master;
        bclk_src = cfg_master ? bclk_o  : bclk_i;
        lr_src   = cfg_master ? lrclk_o : lrclk_i;
    end

    aud_rx_clkgen #(.BCLK_HALF(BCLK_HALF)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_master),
        .len_bits (len_bits),
        .bclk_q   (gen_bclk),
        .lr_q     (gen_lr)
    );

    aud_rx_sampler #(.LINES(LINES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_src (bclk_src),
        .lr_src   (lr_src),
        .dat_src  (sdata_i),
        .bclk_inv (cfg_bclk_inv),
        .lr_pol   (cfg_lr_pol),
        .pipe     (cfg_pipe),
        .cap_stb  (cap_stb),
        .cap_lr   (cap_lr),
        .cap_dat  (cap_dat)
    );

    aud_rx_deser #(.LINES(LINES), .CHANS(CHANS)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_stb  (cap_stb),
        .cap_lr   (cap_lr),
        .cap_dat  (cap_dat),
        .fmt      (cfg_fmt),
        .len_bits (len_bits),
        .dly      (dly_bits),
        .wid      (wid_bits),
        .smp_o    (smp_o),
        .vld_o    (frame_vld_o)
    );

endmodule

// File: rtl/audio_serial_rx_chk.sv
// Property checker for audio_serial_rx, attached by bind below.
// Assumes configuration is static outside reset.
module audio_serial_rx_chk #(
    parameter int CHANS = 8,
    parameter int SW    = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          cfg_fmt,
    input logic [1:0]          cfg_len,
    input logic [1:0]          cfg_width,
    input logic                cfg_master,
    input logic                cfg_bclk_inv,
    input logic                cfg_lr_pol,
    input logic                bclk_o,
    input logic                lrclk_o,
    input logic [CHANS*SW-1:0] smp_o,
    input logic                frame_vld_o
);
    logic low8_any, low4_any, upper_any;

    // Flags over the published sample fields
    always_comb begin
        low8_any  = 1'b0;
        low4_any  = 1'b0;
        upper_any = 1'b0;
        for (int c = 0; c < CHANS; c++) begin
            low8_any = low8_any | (|smp_o[c*SW +: 8]);
            low4_any = low4_any | (|smp_o[c*SW +: 4]);
            if (c >= 2)
                upper_any = upper_any | (|smp_o[c*SW +: SW]);
        end
    end

    AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld_o |=> !frame_vld_o); // R2
    AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld_o |-> $stable(smp_o)); // R2
    AST_ZERO_FILL_16: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld_o && cfg_width == 2'b11) |-> !low8_any); // R6
    AST_ZERO_FILL_20: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld_o && cfg_width == 2'b01) |-> !low4_any); // R6
    AST_UNCARRIED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld_o && (cfg_fmt == 2'b01 || cfg_fmt == 2'b10) && cfg_len == 2'b00)
        |-> !upper_any); // R7
    AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $stable(cfg_master) && $stable(cfg_lr_pol)
         && $stable(cfg_bclk_inv) && !$stable(lrclk_o))
        |-> $fell(bclk_o ^ cfg_bclk_inv)); // R10

endmodule

bind audio_serial_rx audio_serial_rx_chk #(.CHANS(CHANS), .SW(24)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_fmt      (cfg_fmt),
    .cfg_len      (cfg_len),
    .cfg_width    (cfg_width),
    .cfg_master   (cfg_master),
    .cfg_bclk_inv (cfg_bclk_inv),
    .cfg_lr_pol   (cfg_lr_pol),
    .bclk_o       (bclk_o),
    .lrclk_o      (lrclk_o),
    .smp_o        (smp_o),
    .frame_vld_o  (frame_vld_o)
);

// File: tb/audio_serial_rx_tb_top.sv
`timescale 1ns/1ps
module audio_serial_rx_tb_top;
    localparam int LINES = 4;
    localparam int CHANS = 8;
    localparam int HALF  = 4;
    localparam int TBH   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] c_fmt = 0, c_len = 0, c_wid = 0;
    logic [2:0] c_dly = 0;
    logic c_pol = 0, c_inv = 0, c_pipe = 0, c_master = 0;
    logic bclk_i = 0, lrclk_i = 0;
    logic [LINES-1:0] sdata_i = 0;
    logic bclk_o, lrclk_o, clk_oe, frame_vld_o;
    logic [CHANS*24-1:0] smp_o;

    int checks = 0, fails = 0, pulse_cnt = 0;
    bit mon_en = 0;
    int e_len, e_dly, e_wid;
    string cur_req = "R2";

    always #2 clk = ~clk;

    audio_serial_rx #(.LINES(LINES), .CHANS(CHANS), .BCLK_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(c_fmt), .cfg_len(c_len),
        .cfg_delay(c_dly), .cfg_width(c_wid), .cfg_lr_pol(c_pol),
        .cfg_bclk_inv(c_inv), .cfg_pipe(c_pipe), .cfg_master(c_master),
        .bclk_i(bclk_i), .lrclk_i(lrclk_i), .sdata_i(sdata_i),
        .bclk_o(bclk_o), .lrclk_o(lrclk_o), .clk_oe(clk_oe),
        .smp_o(smp_o), .frame_vld_o(frame_vld_o));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Decoded settings per R5, R6, R7
    task automatic decode();
        e_len = 64 << c_len;
        case (c_dly)
            3'b001: e_dly = 0;
            3'b010: e_dly = 8;
            3'b011: e_dly = 12;
            3'b100: e_dly = 16;
            default: e_dly = 1;
        endcase
        e_wid = (c_wid == 2'b01) ? 20 : (c_wid == 2'b11) ? 16 : 24;
    endtask

    function automatic logic [23:0] raw_val(input int fr, input int ch);
        return 24'(fr * 32'h3A5C1 + ch * 32'h1F0B3 + 32'hC35A96);
    endfunction

    function automatic bit carried(input int ch);
        if (c_fmt == 2'b00) return (ch / 2) < LINES;
        if (c_fmt == 2'b11) return (ch < 8) && ((ch % 4) * 32 < e_len);
        return ch * 32 < e_len;
    endfunction

    function automatic logic [23:0] exp_out(input int fr, input int ch);
        logic [23:0] mask;
        mask = 24'hFFFFFF << (24 - e_wid);
        return carried(ch) ? (raw_val(fr, ch) & mask) : 24'h0;
    endfunction

    // Transmitted bit for frame fr, line ln, bit index b
    function automatic logic tx_bit(input int fr, input int ln, input int b);
        int ch, st, off;
        logic [23:0] r;
        if (c_fmt == 2'b00) begin
            ch = 2 * ln + ((b >= e_len / 2) ? 1 : 0);
            st = (b >= e_len / 2) ? e_len / 2 : 0;
        end else if (c_fmt == 2'b11) begin
            if (ln > 1 || b / 32 >= 4) return 1'b0;
            ch = ln * 4 + b / 32;
            st = (b / 32) * 32;
        end else begin
            if (ln != 0) return 1'b0;
            ch = b / 32;
            st = ch * 32;
        end
        off = b - st - e_dly;
        if (off < 0 || off >= e_wid) return 1'b0;
        r = raw_val(fr, ch);
        return r[23 - off];
    endfunction

    // Frame monitor: pulse k carries frame k
    always @(negedge clk) begin
        if (mon_en && frame_vld_o) begin
            for (int ch = 0; ch < CHANS; ch++)
                chk(smp_o[ch*24 +: 24] == exp_out(pulse_cnt, ch), cur_req,
                    32'(smp_o[ch*24 +: 24]), 32'(exp_out(pulse_cnt, ch)));
            pulse_cnt++;
        end
    end

    task automatic send_bit(input logic lr, input logic [LINES-1:0] d);
        bclk_i  = (c_pipe ? 1'b1 : 1'b0) ^ c_inv;
        lrclk_i = lr ^ c_pol;
        sdata_i = d;
        repeat (TBH) @(negedge clk);
        bclk_i  = (c_pipe ? 1'b0 : 1'b1) ^ c_inv;
        repeat (TBH) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        mon_en  = 0;
        bclk_i  = (c_pipe ? 1'b1 : 1'b0) ^ c_inv;
        lrclk_i = 1'b1 ^ c_pol;
        sdata_i = '0;
        decode();
        repeat (4) @(negedge clk);
        rst_n     = 1'b1;
        pulse_cnt = 0;
        mon_en    = 1;
    endtask

    task automatic run_slave(input string req, input logic [1:0] f, input logic [1:0] l,
                             input logic [2:0] dl, input logic [1:0] w,
                             input logic p, input logic iv, input logic pp);
        logic [LINES-1:0] d;
        cur_req = req;
        c_master = 0; c_fmt = f; c_len = l; c_dly = dl; c_wid = w;
        c_pol = p; c_inv = iv; c_pipe = pp;
        do_reset();
        repeat (3) send_bit(1'b1, '0);
        for (int fr = 0; fr < 3; fr++)
            for (int b = 0; b < e_len; b++) begin
                for (int ln = 0; ln < LINES; ln++) d[ln] = tx_bit(fr, ln, b);
                send_bit((b >= e_len / 2) ? 1'b1 : 1'b0, d);
            end
        repeat (4) send_bit(1'b0, '0);
        repeat (10) @(negedge clk);
        chk(pulse_cnt == 3, "R2", 32'(pulse_cnt), 32'd3);
    endtask

    task automatic run_master(input string req, input logic [1:0] f, input logic [1:0] l,
                              input logic [2:0] dl, input logic p, input logic iv);
        logic eff, peff, lr, plr, pb;
        int idx, fr, guard, since, nper;
        cur_req = req;
        c_master = 1; c_fmt = f; c_len = l; c_dly = dl; c_wid = 2'b00;
        c_pol = p; c_inv = iv; c_pipe = 0;
        do_reset();
        peff = 0; plr = 0; idx = 0; fr = -1; guard = 0; since = 0; nper = 0;
        pb = bclk_o;
        chk(clk_oe == 1'b1, "R10", 32'(clk_oe), 32'd1);
        while (pulse_cnt < 3 && guard < 40000) begin
            @(negedge clk);
            guard++;
            since++;
            if (bclk_o != pb) begin
                if (nper > 0 && nper < 8) chk(since == HALF, "R10", 32'(since), 32'(HALF));
                nper++;
                since = 0;
                pb = bclk_o;
            end
            eff = bclk_o ^ c_inv;
            if (peff && !eff) begin
                lr = lrclk_o ^ c_pol;
                if (plr && !lr) begin fr++; idx = 0; end
                else idx++;
                if (lr != plr) chk(lr == (idx >= e_len / 2), "R10", 32'(lr), 32'(idx >= e_len / 2));
                plr = lr;
                for (int ln = 0; ln < LINES; ln++)
                    sdata_i[ln] = (fr >= 0) ? tx_bit(fr, ln, idx) : 1'b0;
            end
            peff = eff;
        end
        chk(pulse_cnt >= 3, "R10", 32'(pulse_cnt), 32'd3);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(smp_o == '0, "R1", 32'(smp_o[31:0]), 32'd0);
        chk(frame_vld_o == 1'b0, "R1", 32'(frame_vld_o), 32'd0);
        chk(clk_oe == 1'b0, "R1", 32'(clk_oe), 32'd0);
        run_slave("R3", 2'b00, 2'b00, 3'b000, 2'b00, 0, 0, 0); // I2S
        run_slave("R8", 2'b00, 2'b00, 3'b001, 2'b00, 1, 0, 0); // LJ, left high
        run_slave("R5", 2'b00, 2'b00, 3'b010, 2'b00, 0, 0, 0); // RJ 24
        run_slave("R9", 2'b00, 2'b01, 3'b011, 2'b01, 0, 1, 0); // inverted clock, 20-bit
        run_slave("R9", 2'b00, 2'b00, 3'b100, 2'b11, 0, 0, 1); // pipeline, 16-bit
        run_slave("R4", 2'b01, 2'b10, 3'b000, 2'b00, 0, 0, 0); // TDM 256
        run_slave("R4", 2'b10, 2'b11, 3'b001, 2'b00, 1, 1, 1); // 512, extra slots ignored
        run_slave("R4", 2'b11, 2'b01, 3'b000, 2'b00, 0, 0, 0); // dual-line
        run_slave("R7", 2'b01, 2'b00, 3'b000, 2'b11, 0, 0, 0); // only two slots carried
        run_slave("R6", 2'b00, 2'b00, 3'b101, 2'b10, 0, 0, 0); // reserved codes
        run_master("R10", 2'b00, 2'b00, 3'b000, 0, 0);
        run_master("R10", 2'b01, 2'b10, 3'b001, 1, 1);
        @(negedge clk);
        rst_n = 1'b0;
        c_master = 0;
        repeat (3) @(negedge clk);
        chk(smp_o == '0, "R1", 32'(smp_o[31:0]), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule